// File: doc/BRIEF.md
# NAND Bank Chip-Enable and Cycle Decoder

This block sits between a simple processor request port and up to four external NAND banks. A small register space holds one control byte with two bits per bank, an enable and a chip-enable assert, plus a status byte. A bank's active-low chip enable falls only when both of its bits are set. Software brackets a sequence of accesses with these bits and then writes bytes into the address window of the bank.

Two address bits in the window offset choose the kind of cycle. With the command bit set, the write becomes a command-latch cycle. With the address bit set, it becomes an address-latch cycle. With neither set, it is a plain data cycle. Each cycle has one setup clock, a write-strobe pulse of a fixed number of clocks and one hold clock, and the latch strobes stay steady through all three. A read at window offset zero pulses the read strobe and returns the byte that sits on the data bus at the end of the pulse. An access that would raise both latch strobes is refused and reported. The ready/busy pin is synchronized and can be read in the status byte.

A request is held until the block answers with a one-cycle acknowledge. The acknowledge carries the read data and an error flag.

Top module: `nand_bank_if`

## Requirements
- R1: While reset is held and right after it, every chip enable is high, CLE and ALE are low, both strobes are high, the data bus is not driven, no acknowledge is given, and the control and status bytes read back as zero while the ready pin is low.
- R2: Region 0 of the address (upper `REGION_W` bits zero) is register space. The control byte sits at offset 0x50 and reads back what was last written. Bank n (1 to 4) is window region n and uses control bit 2(n-1) as its enable and bit 2(n-1)+1 as its assert.
- R3: The chip enable of bank n is low exactly when both of its control bits are set. A write of the old value ANDed with the inverse of 0xAA releases every bank and keeps the enables. A write of zero releases and disables every bank.
- R4: A write to a bank window with offset bit 15 set (offset 0x08000) is a command cycle. CLE is high and ALE is low, the write strobe is low for `PULSE_CYC` clocks, and the written byte is driven with the output enable high while the strobe is low.
- R5: A write with offset bit 16 set (offset 0x10000) is an address cycle. ALE is high, CLE is low, and the strobe and data behave as in R4.
- R6: A write at window offset 0 is a data cycle. CLE and ALE stay low, and the strobe and data behave as in R4.
- R7: A bank-window access with both offset bits 15 and 16 set produces no strobe and is acknowledged with the error flag. It sets bit 1 of the status byte at offset 0x54. Any write to offset 0x54 clears that bit.
- R8: A read at bank-window offset 0 pulses the read strobe low for `PULSE_CYC` clocks with the bus undriven. It returns the byte present on the data input during the last low clock, with no error.
- R9: Status bit 0 follows the ready/busy pin through `SYNC_STAGES` flops. A status read accepted in the same clock as a pin change still returns the old level.
- R10: An access to a region above `NUM_BANKS` is refused with the error flag and no strobe. So is a read at a window offset with bit 15 or bit 16 set.
- R11: CLE and ALE are never high together, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REGION_W+WIN_W | Region in the upper bits, window offset below |
| bus_wdata | input | 8 | Write byte |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Access refused, valid with bus_ack |
| bus_rdata | output | 8 | Read byte, valid with bus_ack |
| nand_ce_n | output | NUM_BANKS | Active-low chip enables, bit n-1 for bank n |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy pin, high when ready |

## Verification
The bench builds the block with its default parameters: four banks, a three-clock strobe pulse and a two-stage ready synchronizer. With four banks, the 0xAA release mask covers every assert bit, and the highest bank's bits 6 and 7 can be reached. The multi-clock pulse makes the down-counter matter, so a miscount changes the measured strobe width. The two-stage synchronizer gives a one-clock lag that a status read issued together with a pin change can see.

// File: rtl/nbk_pkg.sv
package nbk_pkg;

   localparam int NBK_DATA_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_DONE
   } nbk_state_e;

   typedef enum logic [2:0] {
      OP_REG_WR,
      OP_REG_RD,
      OP_NAND_WR,
      OP_NAND_RD,
      OP_REJECT
   } nbk_op_e;

   typedef struct packed {
      nbk_op_e op;
      logic    cle;
      logic    ale;
      logic    is_ctrl;
      logic    is_stat;
   } nbk_dec_t;

endpackage

// File: rtl/nbk_sync.sv
module nbk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-2:0], d};
   end

   assign q = sr_q[STAGES-1];
endmodule

// File: rtl/nbk_decode.sv
module nbk_decode import nbk_pkg::*; #(
   parameter int WIN_W     = 17,
   parameter int REGION_W  = 3,
   parameter int NUM_BANKS = 4,
   parameter int CMD_BIT   = 15,
   parameter int ADR_BIT   = 16,
   parameter int CTRL_OFS  = 'h50,
   parameter int STAT_OFS  = 'h54,
   localparam int ADDR_W   = WIN_W + REGION_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output nbk_dec_t          dec
);
   logic [REGION_W-1:0] region;
   logic [WIN_W-1:0]    ofs;

   assign region = addr[ADDR_W-1:WIN_W];
   assign ofs    = addr[WIN_W-1:0];

   always_comb begin
      dec    = '0;
      dec.op = OP_REJECT;
      if (region == '0) begin
         dec.op      = we ? OP_REG_WR : OP_REG_RD;
         dec.is_ctrl = (ofs == WIN_W'(CTRL_OFS));
         dec.is_stat = (ofs == WIN_W'(STAT_OFS));
      end else if (region <= REGION_W'(NUM_BANKS)) begin
         dec.cle = ofs[CMD_BIT];
         dec.ale = ofs[ADR_BIT];
         if (dec.cle && dec.ale)        dec.op = OP_REJECT;
         else if (we)                   dec.op = OP_NAND_WR;
         else if (dec.cle || dec.ale)   dec.op = OP_REJECT;
         else                           dec.op = OP_NAND_RD;
      end
   end
endmodule

// File: rtl/nbk_bank_ctrl.sv
module nbk_bank_ctrl #(
   parameter int NUM_BANKS = 4,
   localparam int CTRL_W   = 2 * NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [NUM_BANKS-1:0] ce_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign ce_n[b] = ~(ctrl_q[2*b] & ctrl_q[2*b+1]);
   end
endmodule

// File: rtl/nbk_seq.sv
module nbk_seq import nbk_pkg::*; #(
   parameter int PULSE_CYC = 3,
   parameter int CTRL_W    = 8,
   localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  nbk_dec_t              dec,
   input  logic [NBK_DATA_W-1:0] wdata,
   input  logic [NBK_DATA_W-1:0] dq_in,
   input  logic [CTRL_W-1:0]     ctrl_q,
   input  logic                  ready_s,
   output logic                  ctrl_wr,
   output logic                  ack,
   output logic                  err,
   output logic [NBK_DATA_W-1:0] rdata,
   output logic                  cle,
   output logic                  ale,
   output logic                  we_n,
   output logic                  re_n,
   output logic [NBK_DATA_W-1:0] dq_out,
   output logic                  dq_oe
);
   nbk_state_e            state_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  cyc_cle_q, cyc_ale_q, cyc_rd_q;
   logic [NBK_DATA_W-1:0] dq_q, rdata_q;
   logic                  err_q, sticky_q;
   logic                  accept, active;

   assign accept  = req && (state_q == ST_IDLE);
   assign ctrl_wr = accept && (dec.op == OP_REG_WR) && dec.is_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         cyc_cle_q <= 1'b0;
         cyc_ale_q <= 1'b0;
         cyc_rd_q  <= 1'b0;
         dq_q      <= '0;
         rdata_q   <= '0;
         err_q     <= 1'b0;
         sticky_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               err_q   <= 1'b0;
               rdata_q <= '0;
               unique case (dec.op)
                  OP_REG_WR: begin
                     if (dec.is_stat) sticky_q <= 1'b0;
                     state_q <= ST_DONE;
                  end
                  OP_REG_RD: begin
                     if (dec.is_ctrl)
                        rdata_q <= NBK_DATA_W'(ctrl_q);
                     else if (dec.is_stat)
                        rdata_q <= {{(NBK_DATA_W-2){1'b0}}, sticky_q, ready_s};
                     state_q <= ST_DONE;
                  end
                  OP_NAND_WR: begin
                     cyc_cle_q <= dec.cle;
                     cyc_ale_q <= dec.ale;
                     cyc_rd_q  <= 1'b0;
                     dq_q      <= wdata;
                     state_q   <= ST_SETUP;
                  end
                  OP_NAND_RD: begin
                     cyc_cle_q <= 1'b0;
                     cyc_ale_q <= 1'b0;
                     cyc_rd_q  <= 1'b1;
                     state_q   <= ST_SETUP;
                  end
                  default: begin
                     err_q    <= 1'b1;
                     sticky_q <= 1'b1;
                     state_q  <= ST_DONE;
                  end
               endcase
            end
            ST_SETUP: begin
               cnt_q   <= CNT_W'(PULSE_CYC - 1);
               state_q <= ST_PULSE;
            end
            ST_PULSE: begin
               if (cnt_q == '0) begin
                  if (cyc_rd_q) rdata_q <= dq_in;
                  state_q <= ST_HOLD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: state_q <= ST_DONE;
            default: begin
               cyc_cle_q <= 1'b0;
               cyc_ale_q <= 1'b0;
               state_q   <= ST_IDLE;
            end
         endcase
      end
   end

   assign active = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
   assign cle    = active && cyc_cle_q;
   assign ale    = active && cyc_ale_q;
   assign we_n   = !((state_q == ST_PULSE) && !cyc_rd_q);
   assign re_n   = !((state_q == ST_PULSE) && cyc_rd_q);
   assign dq_oe  = active && !cyc_rd_q;
   assign dq_out = dq_q;
   assign ack    = (state_q == ST_DONE);
   assign err    = err_q;
   assign rdata  = rdata_q;
endmodule

// File: rtl/nand_bank_if.sv
module nand_bank_if import nbk_pkg::*; #(
   parameter int NUM_BANKS   = 4,
   parameter int WIN_W       = 17,
   parameter int REGION_W    = 3,
   parameter int CMD_BIT     = 15,
   parameter int ADR_BIT     = 16,
   parameter int CTRL_OFS    = 'h50,
   parameter int STAT_OFS    = 'h54,
   parameter int PULSE_CYC   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_req,
   input  logic                      bus_we,
   input  logic [REGION_W+WIN_W-1:0] bus_addr,
   input  logic [7:0]                bus_wdata,
   output logic                      bus_ack,
   output logic                      bus_err,
   output logic [7:0]                bus_rdata,
   output logic [NUM_BANKS-1:0]      nand_ce_n,
   output logic                      nand_cle,
   output logic                      nand_ale,
   output logic                      nand_we_n,
   output logic                      nand_re_n,
   output logic [7:0]                nand_dq_out,
   output logic                      nand_dq_oe,
   input  logic [7:0]                nand_dq_in,
   input  logic                      nand_rb
);
   localparam int CTRL_W = 2 * NUM_BANKS;

   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("NUM_BANKS must be 1..4 so the control byte holds two bits per bank");
   end
   if ((2 ** REGION_W) <= NUM_BANKS) begin : g_bad_region
      $error("REGION_W too narrow for register region plus NUM_BANKS windows");
   end
   if (CMD_BIT >= WIN_W || ADR_BIT >= WIN_W || CMD_BIT == ADR_BIT) begin : g_bad_bits
      $error("latch select bits must be distinct and inside the window");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("PULSE_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   nbk_dec_t          dec;
   logic [CTRL_W-1:0] ctrl_q;
   logic              ctrl_wr;
   logic              ready_s;

   nbk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(ready_s)
   );

   nbk_decode #(
      .WIN_W(WIN_W), .REGION_W(REGION_W), .NUM_BANKS(NUM_BANKS),
      .CMD_BIT(CMD_BIT), .ADR_BIT(ADR_BIT),
      .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
   ) u_dec (
      .addr(bus_addr), .we(bus_we), .dec(dec)
   );

   nbk_bank_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
      .wdata(bus_wdata[CTRL_W-1:0]), .ctrl_q(ctrl_q), .ce_n(nand_ce_n)
   );

   nbk_seq #(.PULSE_CYC(PULSE_CYC), .CTRL_W(CTRL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(bus_req), .dec(dec),
      .wdata(bus_wdata), .dq_in(nand_dq_in), .ctrl_q(ctrl_q),
      .ready_s(ready_s), .ctrl_wr(ctrl_wr),
      .ack(bus_ack), .err(bus_err), .rdata(bus_rdata),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
   );
endmodule

// File: rtl/nand_bank_if_chk.sv
module nand_bank_if_chk #(
   parameter int PULSE_CYC = 3,
   localparam int CW       = $clog2(PULSE_CYC + 2)
) (
   input logic clk,
   input logic rst_n,
   input logic nand_cle,
   input logic nand_ale,
   input logic nand_we_n,
   input logic nand_re_n,
   input logic nand_dq_oe,
   input logic bus_ack
);
   logic [CW-1:0] we_lo_cnt, re_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         re_lo_cnt <= '0;
      end else begin
         we_lo_cnt <= !nand_we_n ? we_lo_cnt + 1'b1 : '0;
         re_lo_cnt <= !nand_re_n ? re_lo_cnt + 1'b1 : '0;
      end
   end

   a_r11_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   a_r4_latch_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> $stable(nand_cle) && $stable(nand_ale));

   a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> $stable(nand_cle) && $stable(nand_ale));

   a_r4_write_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> (we_lo_cnt == CW'(PULSE_CYC)));

   a_r8_read_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_re_n) |-> (re_lo_cnt == CW'(PULSE_CYC)));

   a_r6_bus_driven_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> nand_dq_oe);

   a_r8_bus_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);

   a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);
endmodule

bind nand_bank_if nand_bank_if_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
   .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe),
   .bus_ack(bus_ack)
);

// File: tb/test_nand_bank_if.sv
module test_nand_bank_if;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_BANKS  = 4;
   localparam int WIN_W      = 17;
   localparam int REGION_W   = 3;
   localparam int PULSE_CYC  = 3;
   localparam int ADDR_W     = WIN_W + REGION_W;
   localparam int OFS_CMD    = 'h08000;
   localparam int OFS_ADR    = 'h10000;
   localparam int OFS_CTRL   = 'h50;
   localparam int OFS_STAT   = 'h54;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic bus_ack, bus_err;
   logic [7:0] bus_rdata;
   logic [NUM_BANKS-1:0] nand_ce_n;
   logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0] nand_dq_out;
   logic [7:0] nand_dq_in = '0;
   logic nand_rb = 1'b0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_bank_if #(
      .NUM_BANKS(NUM_BANKS), .WIN_W(WIN_W), .REGION_W(REGION_W),
      .PULSE_CYC(PULSE_CYC), .SYNC_STAGES(2)
   ) i_nand_bank_if (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_err(bus_err), .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
   );

   typedef struct {
      logic [7:0] rdata;
      logic       err;
      int         we_cyc;
      int         re_cyc;
      logic       cle;
      logic       ale;
      logic [7:0] dq;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] mk(input int region, input int ofs);
      return {REGION_W'(region), WIN_W'(ofs)};
   endfunction

   function automatic exp_t ex_reg(input logic [7:0] rd, input string tag);
      exp_t e;
      e.rdata = rd; e.err = 1'b0; e.we_cyc = 0; e.re_cyc = 0;
      e.cle = 1'b0; e.ale = 1'b0; e.dq = '0; e.tag = tag;
      return e;
   endfunction

   function automatic exp_t ex_rej(input string tag);
      exp_t e;
      e = ex_reg(8'h00, tag);
      e.err = 1'b1;
      return e;
   endfunction

   function automatic exp_t ex_wr(input logic c, input logic a, input logic [7:0] d,
                                  input string tag);
      exp_t e;
      e = ex_reg(8'h00, tag);
      e.we_cyc = PULSE_CYC; e.cle = c; e.ale = a; e.dq = d;
      return e;
   endfunction

   function automatic exp_t ex_rd(input logic [7:0] d, input string tag);
      exp_t e;
      e = ex_reg(d, tag);
      e.re_cyc = PULSE_CYC;
      return e;
   endfunction

   // driver: push the expectation, hold the request until acknowledged
   task automatic xfer(input bit we, input logic [ADDR_W-1:0] a,
                       input logic [7:0] wd, input exp_t e);
      sb_q.push_back(e);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
      do @(negedge clk); while (!bus_ack);
      bus_req = 1'b0;
   endtask

   // monitor: gather what the pins did during one access, compare at ack
   int we_cnt = 0, re_cnt = 0;
   logic saw_cle = 0, saw_ale = 0, saw_both = 0, oe_bad = 0;
   logic [7:0] dq_seen = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!nand_we_n) begin
            we_cnt++;
            dq_seen = nand_dq_out;
            if (!nand_dq_oe) oe_bad = 1'b1;
         end
         if (!nand_re_n) begin
            re_cnt++;
            if (nand_dq_oe) oe_bad = 1'b1;
         end
         if (nand_cle) saw_cle = 1'b1;
         if (nand_ale) saw_ale = 1'b1;
         if (nand_cle && nand_ale) saw_both = 1'b1;
         if (bus_ack) begin
            if (sb_q.size() == 0) begin
               chk("R1", "unexpected ack", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(e.tag, "rdata", bus_rdata, e.rdata);
               chk(e.tag, "err", bus_err, e.err);
               chk(e.tag, "we_n low cycles", we_cnt, e.we_cyc);
               chk(e.tag, "re_n low cycles", re_cnt, e.re_cyc);
               chk(e.tag, "cle seen", saw_cle, e.cle);
               chk(e.tag, "ale seen", saw_ale, e.ale);
               if (e.we_cyc > 0) chk(e.tag, "dq driven", dq_seen, e.dq);
               chk("R11", "cle and ale together", saw_both, 0);
               chk(e.tag, "bus enable during strobe", oe_bad, 0);
            end
            we_cnt = 0; re_cnt = 0;
            saw_cle = 0; saw_ale = 0; saw_both = 0; oe_bad = 0;
         end
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: outputs while reset is held
      repeat (3) @(negedge clk);
      chk("R1", "ce_n", nand_ce_n, 4'hF);
      chk("R1", "cle", nand_cle, 0);
      chk("R1", "ale", nand_ale, 0);
      chk("R1", "we_n", nand_we_n, 1);
      chk("R1", "re_n", nand_re_n, 1);
      chk("R1", "dq_oe", nand_dq_oe, 0);
      chk("R1", "ack", bus_ack, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ce_n after release", nand_ce_n, 4'hF);

      xfer(0, mk(0, OFS_CTRL), 8'h00, ex_reg(8'h00, "R1"));
      xfer(0, mk(0, OFS_STAT), 8'h00, ex_reg(8'h00, "R1"));

      // R2 / R3: control bits and chip enables
      xfer(1, mk(0, OFS_CTRL), 8'h55, ex_reg(8'h00, "R2"));
      chk("R3", "enables only", nand_ce_n, 4'hF);
      xfer(0, mk(0, OFS_CTRL), 8'h00, ex_reg(8'h55, "R2"));
      xfer(1, mk(0, OFS_CTRL), 8'h57, ex_reg(8'h00, "R2"));
      chk("R2", "bank 1 on bits 0,1", nand_ce_n, 4'b1110);
      xfer(1, mk(0, OFS_CTRL), 8'hD5, ex_reg(8'h00, "R2"));
      chk("R2", "bank 4 on bits 6,7", nand_ce_n, 4'b0111);
      xfer(1, mk(0, OFS_CTRL), 8'hA0, ex_reg(8'h00, "R3"));
      chk("R3", "assert without enable", nand_ce_n, 4'hF);
      xfer(1, mk(0, OFS_CTRL), 8'hFF, ex_reg(8'h00, "R3"));
      chk("R3", "all asserted", nand_ce_n, 4'h0);
      xfer(1, mk(0, OFS_CTRL), 8'hFF & ~8'hAA, ex_reg(8'h00, "R3"));
      chk("R3", "mask release", nand_ce_n, 4'hF);
      xfer(0, mk(0, OFS_CTRL), 8'h00, ex_reg(8'h55, "R3"));
      xfer(1, mk(0, OFS_CTRL), 8'h00, ex_reg(8'h00, "R3"));
      chk("R3", "zero disables", nand_ce_n, 4'hF);
      xfer(0, mk(0, OFS_CTRL), 8'h00, ex_reg(8'h00, "R3"));

      // R4..R6: write cycles
      xfer(1, mk(0, OFS_CTRL), 8'h57, ex_reg(8'h00, "R2"));
      xfer(1, mk(1, OFS_CMD), 8'h70, ex_wr(1, 0, 8'h70, "R4"));
      xfer(1, mk(2, OFS_ADR), 8'h12, ex_wr(0, 1, 8'h12, "R5"));
      xfer(1, mk(4, 0),       8'hA5, ex_wr(0, 0, 8'hA5, "R6"));
      xfer(1, mk(3, OFS_CMD), 8'hFF, ex_wr(1, 0, 8'hFF, "R4"));

      // R7: both latch bits refused, sticky status bit
      xfer(1, mk(1, OFS_CMD | OFS_ADR), 8'h33, ex_rej("R7"));
      xfer(0, mk(0, OFS_STAT), 8'h00, ex_reg(8'h02, "R7"));
      xfer(1, mk(0, OFS_STAT), 8'h00, ex_reg(8'h00, "R7"));
      xfer(0, mk(0, OFS_STAT), 8'h00, ex_reg(8'h00, "R7"));

      // R8: data reads
      nand_dq_in = 8'h3C;
      xfer(0, mk(3, 0), 8'h00, ex_rd(8'h3C, "R8"));
      nand_dq_in = 8'hC3;
      xfer(0, mk(1, 0), 8'h00, ex_rd(8'hC3, "R8"));

      // R10: out-of-range regions and reads at latch offsets
      xfer(1, mk(5, 0), 8'h11, ex_rej("R10"));
      xfer(0, mk(7, 0), 8'h00, ex_rej("R10"));
      xfer(0, mk(2, OFS_CMD), 8'h00, ex_rej("R10"));
      xfer(0, mk(2, OFS_ADR), 8'h00, ex_rej("R10"));
      xfer(1, mk(0, OFS_STAT), 8'h00, ex_reg(8'h00, "R10"));

      // R9: ready synchronizer and its lag
      @(negedge clk); nand_rb = 1'b1;
      repeat (4) @(negedge clk);
      xfer(0, mk(0, OFS_STAT), 8'h00, ex_reg(8'h01, "R9"));
      sb_q.push_back(ex_reg(8'h01, "R9"));
      @(negedge clk);
      nand_rb = 1'b0;
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = mk(0, OFS_STAT);
      do @(negedge clk); while (!bus_ack);
      bus_req = 1'b0;
      repeat (4) @(negedge clk);
      xfer(0, mk(0, OFS_STAT), 8'h00, ex_reg(8'h00, "R9"));

      repeat (3) @(negedge clk);
      chk("R1", "scoreboard drained", sb_q.size(), 0);
      summary();
      $finish;
   end
endmodule